// File: doc/BRIEF.md
# Selectable-Polynomial Byte CRC Engine

This block keeps a running 16-bit checksum that is advanced by one byte each time software writes to its data register. A control register picks the generator polynomial: an 8-bit code (x^8+x^2+x+1), one of two 16-bit codes (x^16+x^15+x^2+1 or x^16+x^12+x^5+1), or an idle setting in which bytes are accepted but not folded in. The same register picks the bit order. In LSB-first order the bits of each byte are consumed from bit 0 upward and the register shifts right through the reflected polynomial. This suits links that serialise the low bit first, and on those links the low result byte goes out first. In MSB-first order the bits are consumed from bit 7 downward and the register shifts left through the normal polynomial. On those links the high result byte goes out first.

Software talks to the block over a small synchronous byte bus with four offsets. Offset 0 is control, offset 1 is the data input and offsets 2 and 3 are the result. Writing a 1 to the top control bit zeroes the result. This is the way to start a new message. The seed is always zero and no final inversion is applied.

Top module: `crc_unit`

## Requirements
- R1: After reset, reads at all four offsets (0, 1, 2, 3) return 00h.
- R2: Control at offset 0 holds the polynomial select in bits [1:0] and the bit order in bit 2 (0 = LSB-first, 1 = MSB-first); these read back as written, while bits 7..3 always read 0.
- R3: A control write with bit 7 set forces the result to 0000h; a write with bit 7 clear leaves the result as it was.
- R4: Offset 1 is read/write and returns the last byte written to it.
- R5: Select 01 in MSB-first order folds each byte into the 8-bit code 07h; from a zero result, the ASCII digits "123456789" give 00F4h and the single byte 01h gives 0007h.
- R6: Select 01 in LSB-first order uses the reflected 8-bit code E0h; from zero, the single byte 80h gives 00E0h.
- R7: Select 10 uses 8005h (MSB-first) or A001h (LSB-first); from zero, "123456789" gives FEE8h and BB3Dh respectively, and the single byte 01h in LSB-first order gives C0C1h.
- R8: Select 11 uses 1021h (MSB-first) or 8408h (LSB-first); from zero, "123456789" gives 31C3h and 2189h respectively, and the single byte 01h gives 1021h and 1189h respectively.
- R9: With select 00, data writes leave the result unchanged.
- R10: Changing the select or the bit order without the clear bit leaves the result unchanged.
- R11: Writes to offsets 2 and 3 have no effect on the result.
- R12: The result is read with its low byte at offset 2 and its high byte at offset 3. A data write changes it on the clock edge that accepts the write, and at no other time.
- R13: While the 8-bit code is selected, every fold leaves result bits [15:8] at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register offset for reads and writes |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |

## Verification
The bench uses the default 8-bit bus and 16-bit result. This puts all four select codes and both bit orders within reach, so each polynomial is compared against published zero-seed check values for the nine-digit string and against single-byte results. Directed cases then cover the things that must leave the result alone: the idle select, mode changes, and writes to the result offsets. Further cases cover the clear bit, control bits that read back as zero, and an 8-bit fold that starts from a result whose upper byte is non-zero.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned NUM_SEL = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RESL = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_RESH = 2'd3;

  localparam int unsigned CLR_BIT   = 7;
  localparam int unsigned ORDER_BIT = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_IDLE = 2'd0,
    SEL_C8   = 2'd1,
    SEL_C16A = 2'd2,
    SEL_C16B = 2'd3
  } polySel_e;

  typedef struct packed {
    logic              fold;
    logic              clear;
    logic [BYTE_W-1:0] dataByte;
    polySel_e          sel;
    logic              msbFirst;
  } crcStrobe_t;

  function automatic logic [CRC_W-1:0] polyOf(input int unsigned s);
    case (s)
      1:       return 16'h0007;
      2:       return 16'h8005;
      3:       return 16'h1021;
      default: return '0;
    endcase
  endfunction

  function automatic int unsigned widthOf(input int unsigned s);
    return (s == 1) ? 8 : CRC_W;
  endfunction

  function automatic logic [CRC_W-1:0] reflectPoly(input logic [CRC_W-1:0] p,
                                                   input int unsigned w);
    logic [CRC_W-1:0] r;
    r = '0;
    for (int j = 0; j < CRC_W; j++)
      if (j < int'(w)) r[int'(w) - 1 - j] = p[j];
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] foldByte(input logic [CRC_W-1:0] base,
                                                input logic [BYTE_W-1:0] din,
                                                input logic [CRC_W-1:0] polyN,
                                                input int unsigned w,
                                                input logic msb);
    logic [CRC_W-1:0] c;
    logic [CRC_W-1:0] mask;
    logic [CRC_W-1:0] polyR;
    logic fb;
    mask  = {CRC_W{1'b1}} >> (CRC_W - w);
    polyR = reflectPoly(polyN, w);
    c     = base & mask;
    for (int i = 0; i < BYTE_W; i++) begin
      if (msb) begin
        fb = c[int'(w) - 1] ^ din[BYTE_W - 1 - i];
        c  = (c << 1) & mask;
        if (fb) c = c ^ polyN;
      end else begin
        fb = c[0] ^ din[i];
        c  = c >> 1;
        if (fb) c = c ^ polyR;
      end
    end
    return c & mask;
  endfunction
endpackage

// File: rtl/crc_unit_ctrl.sv
module crc_unit_ctrl
  import crc_unit_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [BYTE_W-1:0]      wrData,
  input  logic [CRC_W-1:0]       crcVal,
  output crcStrobe_t             strb,
  output logic [BYTE_W-1:0]      rdData
);
  polySel_e          selQ;
  logic              orderQ;
  logic [BYTE_W-1:0] dataQ;

  logic ctrlWr;
  logic dataWr;

  assign ctrlWr = wrEn && (addr == OFS_CTRL);
  assign dataWr = wrEn && (addr == OFS_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= SEL_IDLE;
      orderQ <= 1'b0;
      dataQ  <= '0;
    end else begin
      if (ctrlWr) begin
        selQ   <= polySel_e'(wrData[SEL_W-1:0]);
        orderQ <= wrData[ORDER_BIT];
      end
      if (dataWr) dataQ <= wrData;
    end
  end

  always_comb begin
    strb.fold     = dataWr;
    strb.clear    = ctrlWr && wrData[CLR_BIT];
    strb.dataByte = wrData;
    strb.sel      = selQ;
    strb.msbFirst = orderQ;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      OFS_CTRL: begin
        rdData[SEL_W-1:0] = selQ;
        rdData[ORDER_BIT] = orderQ;
      end
      OFS_DATA: rdData = dataQ;
      OFS_RESL: rdData = crcVal[BYTE_W-1:0];
      default:  rdData = crcVal[CRC_W-1:BYTE_W];
    endcase
  end
endmodule

// File: rtl/crc_unit_dp.sv
module crc_unit_dp
  import crc_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobe_t       strb,
  output logic [CRC_W-1:0] crcVal
);
  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] baseVal;
  logic [CRC_W-1:0] cand [NUM_SEL];

  // a clear in the same cycle is applied before the byte is folded
  assign baseVal = strb.clear ? '0 : crcQ;
  assign cand[0] = baseVal;

  for (genvar g = 1; g < NUM_SEL; g++) begin : g_poly
    assign cand[g] = foldByte(baseVal, strb.dataByte, polyOf(g), widthOf(g),
                              strb.msbFirst);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           crcQ <= '0;
    else if (strb.fold)  crcQ <= cand[strb.sel];
    else if (strb.clear) crcQ <= '0;
  end

  assign crcVal = crcQ;
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  crcStrobe_t       strb;
  logic [CRC_W-1:0] crcVal;
  polySel_e         polySel;

  assign polySel = strb.sel;

  crc_unit_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .crcVal (crcVal),
    .strb   (strb),
    .rdData (rdData)
  );

  crc_unit_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .crcVal (crcVal)
  );
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  addr,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic [1:0]  polySel,
  input logic [15:0] crcVal
);
  a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && wrData[7]) |=> (crcVal == 16'h0000));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd0) |-> (rdData[7:3] == 5'd0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && polySel == 2'd0) |=> $stable(crcVal));

  a_r11_result_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[1]) |=> $stable(crcVal));

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> $stable(crcVal));

  a_r13_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && polySel == 2'd1) |=> (crcVal[15:8] == 8'h00));
endmodule

bind crc_unit crc_unit_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .polySel (polySel),
  .crcVal  (crcVal)
);

// File: tb/crc_unit_bench.sv
module crc_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int errCount = 0;
  int chkCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crc_unit u_crc_unit (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        msb;
    logic [7:0]  first;
    logic [3:0]  cnt;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b1, 8'h31, 4'd9, 16'h00F4},
    '{2'd2, 1'b0, 8'h31, 4'd9, 16'hBB3D},
    '{2'd3, 1'b1, 8'h31, 4'd9, 16'h31C3},
    '{2'd3, 1'b0, 8'h31, 4'd9, 16'h2189},
    '{2'd2, 1'b1, 8'h31, 4'd9, 16'hFEE8},
    '{2'd1, 1'b1, 8'h01, 4'd1, 16'h0007},
    '{2'd1, 1'b0, 8'h80, 4'd1, 16'h00E0},
    '{2'd2, 1'b0, 8'h01, 4'd1, 16'hC0C1},
    '{2'd3, 1'b1, 8'h01, 4'd1, 16'h1021},
    '{2'd3, 1'b0, 8'h01, 4'd1, 16'h1189},
    '{2'd0, 1'b1, 8'h31, 4'd9, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%04h expected=%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic readResult(output logic [15:0] v);
    logic [7:0] lo;
    logic [7:0] hi;
    busRead(2'd2, lo);
    busRead(2'd3, hi);
    v = {hi, lo};
  endtask

  function automatic string tagOf(input logic [1:0] s, input logic m);
    case (s)
      2'd1:    return m ? "R5" : "R6";
      2'd2:    return "R7";
      2'd3:    return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] r;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state at every offset
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), b);
      check("R1", {8'h00, b}, 16'h0000);
    end

    // table of vectors, each starting from a cleared result
    for (int v = 0; v < NVEC; v++) begin
      busWrite(2'd0, {1'b1, 4'b0000, VECS[v].msb, VECS[v].sel});
      for (int k = 0; k < int'(VECS[v].cnt); k++)
        busWrite(2'd1, VECS[v].first + 8'(k));
      readResult(r);
      check(tagOf(VECS[v].sel, VECS[v].msb), r, VECS[v].exp);
    end

    // R2: control readback, reserved and clear bits read 0
    busWrite(2'd0, 8'hFF);
    busRead(2'd0, b);
    check("R2", {8'h00, b}, 16'h0007);
    busWrite(2'd0, 8'h7A);
    busRead(2'd0, b);
    check("R2", {8'h00, b}, 16'h0002);

    // R4: data register readback
    busWrite(2'd1, 8'h5A);
    busRead(2'd1, b);
    check("R4", {8'h00, b}, 16'h005A);

    // build a known result: MSB-first 1021h over "123456789"
    busWrite(2'd0, 8'h87);
    for (int k = 0; k < 9; k++) busWrite(2'd1, 8'h31 + 8'(k));
    readResult(r);
    check("R8", r, 16'h31C3);

    // R10: changing order and select without clear keeps result
    busWrite(2'd0, 8'h03);
    readResult(r);
    check("R10", r, 16'h31C3);
    busWrite(2'd0, 8'h05);
    readResult(r);
    check("R10", r, 16'h31C3);

    // R9: idle select ignores data
    busWrite(2'd0, 8'h04);
    busWrite(2'd1, 8'hA5);
    busWrite(2'd1, 8'h3C);
    readResult(r);
    check("R9", r, 16'h31C3);

    // R11: writes to result offsets ignored
    busWrite(2'd2, 8'hFF);
    busWrite(2'd3, 8'hEE);
    readResult(r);
    check("R11", r, 16'h31C3);

    // R3: control write without clear bit keeps result
    busWrite(2'd0, 8'h07);
    readResult(r);
    check("R3", r, 16'h31C3);

    // R13: 8-bit fold from a result with non-zero upper byte
    busWrite(2'd0, 8'h05);
    busWrite(2'd1, 8'h00);
    busRead(2'd3, b);
    check("R13", {8'h00, b}, 16'h0000);

    // R3: clear bit zeroes the result
    busWrite(2'd0, 8'h87);
    readResult(r);
    check("R3", r, 16'h0000);

    // R12: update lands on the accepting edge, low/high byte placement
    @(negedge clk);
    addr = 2'd1; wrData = 8'h01; wrEn = 1'b1;
    busRead(2'd3, b);
    check("R12", {8'h00, b}, 16'h0000);
    addr = 2'd1;
    @(negedge clk);
    wrEn = 1'b0;
    busRead(2'd3, b);
    check("R12", {8'h00, b}, 16'h0010);
    busRead(2'd2, b);
    check("R12", {8'h00, b}, 16'h0021);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule